// File: doc/BRIEF.md
# I2C Target With Clock Stretching

This block is a 7-bit-address I2C target that runs from a system clock much faster than SCL. Both bus lines pass through a synchroniser, and edges and bus conditions are found by comparing successive synchronised samples. Each output is a drive-low enable for an open-drain pad. After a START the block shifts in the address byte and compares it with a programmable own address. When the address matches, the block acknowledges it. It then receives data bytes into a host-visible buffer, or it sends bytes that the host supplies.

The host side uses simple single-cycle strobes. One strobe writes the data buffer, and that write also loads the transmit shift register. Another strobe reads the buffer and clears the full flag. A clock-release strobe ends a transmit stall. Two write-one-to-clear strobes clear the interrupt flag and the overflow flag. In transmit mode the block holds SCL low after every acknowledged byte until the host has loaded new data and released the clock. A byte that arrives while the buffer is still full is refused with a NACK and is reported as an overflow.

Top module: `i2c_target`

## Requirements
- R1: After reset both drive-low enables are 0 and buffer-full, direction, overflow and interrupt are all 0.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. A START, including one in the middle of a byte, returns the block to address reception. After a STOP, SCL pulses are ignored until the next START.
- R3: The address byte carries the address in bits 7..1 and R/W in bit 0, and arrives MSB first. On a match the block drives SDA low during the ninth SCL pulse, and the direction flag takes bit 0. On a mismatch the block sends no ACK, leaves every flag and the buffer unchanged, and ignores the bus until a START.
- R4: A matching address with R/W=1 sets the direction flag and places the whole address byte into the buffer.
- R5: The interrupt flag is set on the falling edge of the ninth SCL pulse of each handled byte, the address byte included. Only the irq_clr strobe clears it.
- R6: In receive mode a completed byte is moved to the buffer, buffer-full is set and the byte is acknowledged. A host read clears buffer-full.
- R7: If a received byte completes while buffer-full is still set, the overflow flag is set, the byte gets no ACK and the buffer keeps its old value. ovf_clr clears the overflow flag.
- R8: In transmit mode SCL is held low from the falling edge of the ninth pulse. The hold ends only on a clock-release strobe that comes after a buffer write made since the stall began. A release with no such write is ignored.
- R9: Transmit bits go out MSB first. SDA changes only while SCL is low, so it is stable for the whole SCL high time. Buffer-full clears once all eight bits have been shifted out.
- R10: The master's ACK bit is sampled on the rising edge of the ninth pulse. On ACK the block stalls again as in R8. On NACK it releases both lines and ignores the bus until a START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretch) |
| sda_oe | output | 1 | 1 pulls SDA low |
| own_addr | input | 7 | Own 7-bit target address |
| host_wr | input | 1 | Buffer write strobe; also loads the transmit shifter |
| host_wdata | input | 8 | Data for host_wr |
| host_rd | input | 1 | Buffer read strobe; clears buffer-full |
| host_rdata | output | 8 | Buffer contents |
| clk_release | input | 1 | Clock-release strobe for transmit stalls |
| irq_clr | input | 1 | Clears the interrupt flag |
| ovf_clr | input | 1 | Clears the overflow flag |
| buf_full | output | 1 | Buffer-full flag |
| dir_rd | output | 1 | Direction: 1 when the master reads |
| ovf | output | 1 | Overflow flag |
| irq | output | 1 | Per-byte interrupt flag |

## Verification
The assertions check several rules on every cycle. SDA drive changes only while synchronised SCL is low or at a bus condition. Stretching begins only at an SCL falling edge. The stretch ends only after a buffer load. The interrupt flag rises only at an SCL falling edge. An overflow arises only with the buffer full and never together with an ACK. Other behaviour can only be shown by the bench's scenarios. These cover address matching and mismatch, the byte values received and sent MSB first, a release that is ignored, the stall repeating after a master ACK, the return to idle after a master NACK, and recovery through a repeated START or a STOP.

// File: rtl/i2c_target.sv
module i2c_target #(
  parameter int SYNC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  input  logic [6:0] own_addr,
  input  logic       host_wr,
  input  logic [7:0] host_wdata,
  input  logic       host_rd,
  output logic [7:0] host_rdata,
  input  logic       clk_release,
  input  logic       irq_clr,
  input  logic       ovf_clr,
  output logic       buf_full,
  output logic       dir_rd,
  output logic       ovf,
  output logic       irq
);

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_RX, S_STALL, S_TX} st_t;

  logic [SYNC-1:0] scl_sy, sda_sy;
  logic            scl_q, sda_q;
  logic            scl_s, sda_s;
  logic            scl_rise, scl_fall, start_c, stop_c, bus_evt;

  st_t        st;
  logic [3:0] cnt;
  logic [7:0] sr, tsr, dbuf;
  logic       loaded, nak;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1;
      sda_sy <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s    = scl_sy[SYNC-1];
  assign sda_s    = sda_sy[SYNC-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign bus_evt  = start_c | stop_c;
  assign host_rdata = dbuf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      sr       <= '0;
      tsr      <= '0;
      dbuf     <= '0;
      loaded   <= 1'b0;
      nak      <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      buf_full <= 1'b0;
      dir_rd   <= 1'b0;
      ovf      <= 1'b0;
      irq      <= 1'b0;
    end else begin
      if (irq_clr) irq <= 1'b0;
      if (ovf_clr) ovf <= 1'b0;
      if (host_rd) buf_full <= 1'b0;
      if (host_wr) begin
        dbuf     <= host_wdata;
        tsr      <= host_wdata;
        loaded   <= 1'b1;
        buf_full <= 1'b1;
      end

      if (bus_evt) begin
        st     <= start_c ? S_ADDR : S_IDLE;
        cnt    <= '0;
        sda_oe <= 1'b0;
        scl_oe <= 1'b0;
      end else begin
        case (st)
          S_IDLE: ;
          S_ADDR: begin
            if (scl_rise) begin
              if (cnt < 4'd8) sr <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (sr[7:1] == own_addr) begin
                sda_oe <= 1'b1;
                dir_rd <= sr[0];
                if (sr[0]) dbuf <= sr;
              end else begin
                st <= S_IDLE;
              end
            end else if (scl_fall && cnt == 4'd9) begin
              sda_oe <= 1'b0;
              irq    <= 1'b1;
              cnt    <= '0;
              if (dir_rd) begin
                st     <= S_STALL;
                scl_oe <= 1'b1;
                loaded <= host_wr;
              end else begin
                st <= S_RX;
              end
            end
          end
          S_RX: begin
            if (scl_rise) begin
              if (cnt < 4'd8) sr <= {sr[6:0], sda_s};
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt == 4'd8) begin
              if (buf_full) begin
                ovf <= 1'b1;
              end else begin
                dbuf     <= sr;
                buf_full <= 1'b1;
                sda_oe   <= 1'b1;
              end
            end else if (scl_fall && cnt == 4'd9) begin
              sda_oe <= 1'b0;
              irq    <= 1'b1;
              cnt    <= '0;
            end
          end
          S_STALL: begin
            scl_oe <= 1'b1;
            if (clk_release && loaded) begin
              sda_oe <= ~tsr[7];
              tsr    <= {tsr[6:0], 1'b0};
              cnt    <= '0;
              st     <= S_TX;
            end
          end
          S_TX: begin
            scl_oe <= 1'b0;
            if (scl_rise) begin
              if (cnt == 4'd8) nak <= sda_s;
              cnt <= cnt + 4'd1;
            end else if (scl_fall && cnt != 4'd0 && cnt < 4'd8) begin
              sda_oe <= ~tsr[7];
              tsr    <= {tsr[6:0], 1'b0};
            end else if (scl_fall && cnt == 4'd8) begin
              sda_oe   <= 1'b0;
              buf_full <= 1'b0;
            end else if (scl_fall && cnt == 4'd9) begin
              irq <= 1'b1;
              cnt <= '0;
              if (nak) begin
                st <= S_IDLE;
              end else begin
                st     <= S_STALL;
                scl_oe <= 1'b1;
                loaded <= host_wr;
              end
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_target_chk.sv
module i2c_target_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_s,
  input logic scl_fall,
  input logic bus_evt,
  input logic loaded,
  input logic scl_oe,
  input logic sda_oe,
  input logic irq,
  input logic ovf,
  input logic buf_full
);

  assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> (!$past(scl_s) || $past(bus_evt)));

  assert_stretch_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_oe) |-> $past(scl_fall));

  assert_release_after_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_oe) |-> ($past(loaded) || $past(bus_evt)));

  assert_irq_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(scl_fall));

  assert_ovf_needs_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> $past(buf_full));

  assert_ovf_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf) |-> !sda_oe);

endmodule

bind i2c_target i2c_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .scl_fall(scl_fall),
  .bus_evt(bus_evt), .loaded(loaded), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .irq(irq), .ovf(ovf), .buf_full(buf_full)
);

// File: tb/i2c_target_tb.sv
module i2c_target_tb;
  localparam int Q = 20;
  localparam logic [6:0] ADDR = 7'h2A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe, sda_oe;
  logic host_wr = 0, host_rd = 0, clk_release = 0, irq_clr = 0, ovf_clr = 0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic buf_full, dir_rd, ovf, irq;
  logic scl_bus, sda_bus;
  int n_tests = 0, n_fail = 0, cyc = 0;

  always #2 clk = ~clk;
  assign scl_bus = scl_m & ~scl_oe;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_target u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(ADDR),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
    .host_rdata(host_rdata), .clk_release(clk_release), .irq_clr(irq_clr),
    .ovf_clr(ovf_clr), .buf_full(buf_full), .dir_rd(dir_rd), .ovf(ovf), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_q(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic pulse(input int which);
    @(negedge clk);
    case (which)
      0: host_rd = 1; 1: clk_release = 1; 2: irq_clr = 1; default: ovf_clr = 1;
    endcase
    @(negedge clk);
    host_rd = 0; clk_release = 0; irq_clr = 0; ovf_clr = 0;
    @(negedge clk);
  endtask

  task automatic h_write(input logic [7:0] v);
    @(negedge clk); host_wr = 1; host_wdata = v;
    @(negedge clk); host_wr = 0;
    @(negedge clk);
  endtask

  task automatic m_start;
    sda_m = 1; wait_q(Q); scl_m = 1; wait_q(Q); sda_m = 0; wait_q(Q); scl_m = 0; wait_q(Q);
  endtask

  task automatic m_stop;
    sda_m = 0; wait_q(Q); scl_m = 1; wait_q(Q); sda_m = 1; wait_q(Q);
  endtask

  task automatic m_bit(input logic b, output logic r, output logic stable);
    logic s0;
    sda_m = b; wait_q(Q); scl_m = 1;
    while (!scl_bus) @(negedge clk);
    wait_q(2);
    s0 = sda_bus;
    wait_q(Q);
    r = sda_bus; stable = (r == s0);
    scl_m = 0; wait_q(Q);
  endtask

  task automatic m_wbyte(input logic [7:0] v, output logic ack);
    logic r, s;
    for (int i = 7; i >= 0; i--) m_bit(v[i], r, s);
    m_bit(1'b1, r, s);
    ack = ~r;
  endtask

  task automatic m_rbyte(input logic ack, output logic [7:0] v, output logic stable);
    logic r, s;
    stable = 1;
    for (int i = 7; i >= 0; i--) begin
      m_bit(1'b1, r, s); v[i] = r; stable &= s;
    end
    m_bit(~ack, r, s);
  endtask

  task automatic t_reset;
    chk("R1 scl_oe", scl_oe, 0); chk("R1 sda_oe", sda_oe, 0);
    chk("R1 flags", {buf_full, dir_rd, ovf, irq}, 0);
  endtask

  task automatic t_write;
    logic a;
    m_start;
    m_wbyte({ADDR, 1'b0}, a);
    chk("R3 addr ack", a, 1); chk("R3 dir", dir_rd, 0); chk("R5 irq addr", irq, 1);
    pulse(2);
    m_wbyte(8'h5C, a);
    chk("R6 data ack", a, 1); chk("R6 full", buf_full, 1);
    chk("R6 data", host_rdata, 8'h5C); chk("R5 irq data", irq, 1);
    pulse(0);
    chk("R6 read clears full", buf_full, 0);
    chk("R5 irq kept after read", irq, 1);
    pulse(2);
    chk("R5 irq cleared", irq, 0);
    m_stop;
  endtask

  task automatic t_overflow;
    logic a;
    m_start;
    m_wbyte({ADDR, 1'b0}, a);
    m_wbyte(8'h11, a);
    chk("R6 first ack", a, 1);
    m_wbyte(8'h22, a);
    chk("R7 nak", a, 0); chk("R7 ovf", ovf, 1);
    chk("R7 buffer kept", host_rdata, 8'h11);
    pulse(0); pulse(3); pulse(2);
    chk("R7 ovf cleared", ovf, 0);
    m_stop;
  endtask

  task automatic t_mismatch;
    logic a, r, s;
    m_start;
    m_wbyte({7'h2B, 1'b0}, a);
    chk("R3 mismatch nak", a, 0); chk("R3 mismatch irq", irq, 0);
    m_wbyte(8'h54, a);
    chk("R3 ignored byte", a, 0);
    chk("R3 flags untouched", {buf_full, ovf, irq}, 0);
    m_stop;
    scl_m = 0; wait_q(Q);
    m_wbyte({ADDR, 1'b0}, a);
    chk("R2 no start ignored", a, 0);
    m_start;
    m_wbyte({ADDR, 1'b0}, a);
    chk("R2 after start ack", a, 1);
    m_bit(1'b1, r, s); m_bit(1'b0, r, s); m_bit(1'b1, r, s);
    m_start;
    m_wbyte({ADDR, 1'b0}, a);
    chk("R2 repeated start ack", a, 1);
    pulse(2);
    m_stop;
  endtask

  task automatic t_read;
    logic a, s;
    logic [7:0] d;
    m_start;
    m_wbyte({ADDR, 1'b1}, a);
    chk("R3 read addr ack", a, 1); chk("R4 dir", dir_rd, 1);
    chk("R4 addr in buffer", host_rdata, {ADDR, 1'b1}); chk("R5 irq", irq, 1);
    pulse(2);
    wait_q(2 * Q);
    chk("R8 stall", scl_oe, 1);
    pulse(1);
    wait_q(2 * Q);
    chk("R8 release ignored", scl_oe, 1);
    h_write(8'hA5);
    wait_q(Q);
    chk("R8 write alone holds", scl_oe, 1);
    pulse(1);
    m_rbyte(1'b1, d, s);
    chk("R9 data", d, 8'hA5); chk("R9 stable", s, 1);
    chk("R9 full cleared", buf_full, 0); chk("R5 irq tx", irq, 1);
    wait_q(Q);
    chk("R10 stall again", scl_oe, 1);
    pulse(2);
    h_write(8'h3C);
    pulse(1);
    m_rbyte(1'b0, d, s);
    chk("R9 data2", d, 8'h3C);
    wait_q(Q);
    chk("R10 nak releases scl", scl_oe, 0); chk("R10 nak releases sda", sda_oe, 0);
    pulse(2);
    m_wbyte({ADDR, 1'b1}, a);
    chk("R10 idle after nak", a, 0); chk("R10 no irq", irq, 0);
    m_stop;
  endtask

  initial begin
    wait_q(5);
    t_reset;
    rst_n = 1;
    wait_q(5);
    t_write;
    t_overflow;
    t_mismatch;
    t_read;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule